// File: doc/BRIEF.md
# Bidirectional Dual-Bus Shift Register

This block is an 8-stage storage register placed between two 8-bit buses, A and B. A direction control chooses which bus feeds the register and which bus the register drives. In parallel mode the register takes a whole word from the feeding bus. It can do this on the rising clock edge, or through a transparent path that passes the word at once. In serial mode it shifts one bit per clock from a serial input. The last stage is brought out so that several devices can be chained into a longer register.

Each bus is modelled as an input vector, an output vector and an output enable, so the surrounding logic resolves the tri-state. An enable input for the A side floats the A lines, which lets many registers share that bus. When A is the feeding side and its enable is low, the register recirculates its own contents and holds its value.

Top module: `dual_bus_shreg`

## Requirements
- R1: With `dirAtoB` = 1, bus A is the source and the register drives bus B: `bOe` = 1 and `aOe` = 0 (out of reset).
- R2: With `dirAtoB` = 0, bus B is the source and the register drives bus A. `aOe` equals `aEnable` and `bOe` = 0.
- R3: With `parMode` = 1 and `asyncMode` = 0, the selected source word is stored on the rising clock edge. The driven bus shows the new word after that edge and not before it.
- R4: With `parMode` = 1 and `asyncMode` = 1, the driven bus follows the selected source word with no clock edge needed. The register captures that word on every rising edge and keeps the last captured word after the mode ends.
- R5: With `parMode` = 1, `dirAtoB` = 1 and `aEnable` = 0, the stored word recirculates. It does not change across clock edges, whatever is on `aIn`.
- R6: With `parMode` = 0, each rising edge moves stage k into stage k+1 and loads `serIn` into stage 1. Stage 1 is bit 0 and stage 8 is bit 7 of the word. The driven bus shows the whole register throughout.
- R7: In serial mode, `asyncMode` = 1 has no effect. The register changes only on clock edges, and a change on `serIn` between edges leaves the driven bus unchanged.
- R8: `serOut` carries stage 8 (bit 7) of the register, for cascading into the `serIn` of the next device.
- R9: `rstN` low at a rising edge clears all stages to 0. While `rstN` is low, `aOe` and `bOe` are both 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| dirAtoB | input | 1 | 1: A is the source and B is driven; 0: B is the source and A is driven |
| aEnable | input | 1 | A-bus enable; 0 floats the A lines |
| parMode | input | 1 | 1: parallel load; 0: serial shift |
| asyncMode | input | 1 | 1: transparent parallel transfer; 0: clocked transfer |
| serIn | input | 1 | Serial data into stage 1 |
| aIn | input | 8 | Value sensed on bus A |
| aOut | output | 8 | Value offered to bus A |
| aOe | output | 1 | Output enable for bus A |
| bIn | input | 8 | Value sensed on bus B |
| bOut | output | 8 | Value offered to bus B |
| bOe | output | 1 | Output enable for bus B |
| serOut | output | 1 | Stage 8, for cascading |

## Verification
Clocked results appear one edge after their stimulus: loads, shifts, holds and reset pass through a single register stage. The bench changes inputs 5 ns after an edge and samples 5 ns after the next edge. It also samples just before an edge, to show that nothing moved early. Transparent transfers and output enables take zero cycles. For these the bench changes an input and samples 1 ns later with no edge in between, so a result that waited for the clock is caught. During serial fills a reference word is advanced once per edge and compared with the bus and with `serOut`.

// File: rtl/dbr_pkg.sv
package dbr_pkg;

  // Strobes passed from the control decoder to the datapath
  typedef struct packed {
    logic shiftEn;     // serial shift on next edge
    logic loadEn;      // parallel capture on next edge
    logic passThru;    // transparent path to the driven bus
    logic srcIsA;      // source bus select: 1 = A, 0 = B
    logic driveA;      // output enable for bus A
    logic driveB;      // output enable for bus B
  } dbrStrobes_t;

endpackage

// File: rtl/dbr_ctrl.sv
module dbr_ctrl
  import dbr_pkg::*;
(
  input  logic        rstN,
  input  logic        dirAtoB,
  input  logic        aEnable,
  input  logic        parMode,
  input  logic        asyncMode,
  output dbrStrobes_t strobes
);

  logic srcValid;

  // A source only counts when its lines are enabled; B is always usable
  assign srcValid = dirAtoB ? aEnable : 1'b1;

  always_comb begin
    strobes          = '0;
    strobes.srcIsA   = dirAtoB;
    strobes.shiftEn  = ~parMode;
    // Parallel with an invalid source leaves the load off, so the stages recirculate
    strobes.loadEn   = parMode & srcValid;
    // Asynchronous transfer is only honoured in parallel mode
    strobes.passThru = parMode & asyncMode & srcValid;
    strobes.driveA   = rstN & ~dirAtoB & aEnable;
    strobes.driveB   = rstN & dirAtoB;
  end

endmodule

// File: rtl/dbr_datapath.sv
module dbr_datapath
  import dbr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dbrStrobes_t      strobes,
  input  logic             serIn,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] storedWord,
  output logic [WIDTH-1:0] busWord,
  output logic             serOut
);

  localparam int LAST = WIDTH - 1;

  logic [WIDTH-1:0] srcWord;
  logic [WIDTH:0]   chainIn;

  assign srcWord    = strobes.srcIsA ? aIn : bIn;
  assign chainIn[0] = serIn;

  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_stage
      logic stageQ;
      always_ff @(posedge clk) begin
        if (!rstN)                stageQ <= 1'b0;
        else if (strobes.shiftEn) stageQ <= chainIn[gi];
        else if (strobes.loadEn)  stageQ <= srcWord[gi];
      end
      assign chainIn[gi+1]  = stageQ;
      assign storedWord[gi] = stageQ;
    end
  endgenerate

  assign busWord = strobes.passThru ? srcWord : storedWord;
  assign serOut  = chainIn[LAST+1];

endmodule

// File: rtl/dual_bus_shreg.sv
module dual_bus_shreg
  import dbr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dirAtoB,
  input  logic             aEnable,
  input  logic             parMode,
  input  logic             asyncMode,
  input  logic             serIn,
  input  logic [WIDTH-1:0] aIn,
  output logic [WIDTH-1:0] aOut,
  output logic             aOe,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] bOut,
  output logic             bOe,
  output logic             serOut
);

  dbrStrobes_t      strobes;
  logic [WIDTH-1:0] storedWord;
  logic [WIDTH-1:0] busWord;

  dbr_ctrl u_ctrl (
    .rstN      (rstN),
    .dirAtoB   (dirAtoB),
    .aEnable   (aEnable),
    .parMode   (parMode),
    .asyncMode (asyncMode),
    .strobes   (strobes)
  );

  dbr_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .serIn      (serIn),
    .aIn        (aIn),
    .bIn        (bIn),
    .storedWord (storedWord),
    .busWord    (busWord),
    .serOut     (serOut)
  );

  assign aOut = busWord;
  assign bOut = busWord;
  assign aOe  = strobes.driveA;
  assign bOe  = strobes.driveB;

endmodule

// File: rtl/dbr_checker.sv
module dbr_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             dirAtoB,
  input logic             aEnable,
  input logic             parMode,
  input logic             asyncMode,
  input logic             serIn,
  input logic [WIDTH-1:0] aIn,
  input logic [WIDTH-1:0] bIn,
  input logic [WIDTH-1:0] aOut,
  input logic [WIDTH-1:0] bOut,
  input logic             aOe,
  input logic             bOe,
  input logic             serOut,
  input logic [WIDTH-1:0] storedWord
);

  p_drive_b_r1: assert property (@(posedge clk) disable iff (!rstN)
    bOe |-> (dirAtoB && !aOe));

  p_drive_a_r2: assert property (@(posedge clk) disable iff (!rstN)
    aOe |-> (!dirAtoB && aEnable && !bOe));

  p_sync_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    (parMode && !asyncMode && (!dirAtoB || aEnable))
      |=> storedWord == $past(dirAtoB ? aIn : bIn));

  p_pass_thru_r4: assert property (@(posedge clk) disable iff (!rstN)
    (parMode && asyncMode && (!dirAtoB || aEnable))
      |-> (dirAtoB ? (bOut == aIn) : (aOut == bIn)));

  p_recirc_r5: assert property (@(posedge clk) disable iff (!rstN)
    (parMode && dirAtoB && !aEnable) |=> $stable(storedWord));

  p_shift_r6: assert property (@(posedge clk) disable iff (!rstN)
    !parMode |=> storedWord == {$past(storedWord[WIDTH-2:0]), $past(serIn)});

  p_tail_r8: assert property (@(posedge clk) disable iff (!rstN)
    !parMode |=> serOut == $past(storedWord[WIDTH-2]));

endmodule

bind dual_bus_shreg dbr_checker #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .dirAtoB    (dirAtoB),
  .aEnable    (aEnable),
  .parMode    (parMode),
  .asyncMode  (asyncMode),
  .serIn      (serIn),
  .aIn        (aIn),
  .bIn        (bIn),
  .aOut       (aOut),
  .bOut       (bOut),
  .aOe        (aOe),
  .bOe        (bOe),
  .serOut     (serOut),
  .storedWord (storedWord)
);

// File: tb/tb_dual_bus_shreg.sv
`timescale 1ns/1ps
module tb_dual_bus_shreg;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       dirAtoB = 1'b1, aEnable = 1'b0, parMode = 1'b1, asyncMode = 1'b0, serIn = 1'b0;
  logic [7:0] aIn = '0, bIn = '0;
  logic [7:0] aOut, bOut;
  logic       aOe, bOe, serOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #10 clk = ~clk;  // 50 MHz

  dual_bus_shreg dut (
    .clk(clk), .rstN(rstN), .dirAtoB(dirAtoB), .aEnable(aEnable),
    .parMode(parMode), .asyncMode(asyncMode), .serIn(serIn),
    .aIn(aIn), .aOut(aOut), .aOe(aOe),
    .bIn(bIn), .bOut(bOut), .bOe(bOe), .serOut(serOut)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // advance to 5 ns after the next rising edge
  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    tick();
    check("R9 aOe low in reset", {7'b0, aOe}, 8'h00);
    check("R9 bOe low in reset", {7'b0, bOe}, 8'h00);
    tick();
    check("R9 cleared word", bOut, 8'h00);
    rstN = 1'b1;
    tick();
  endtask

  task automatic testSyncLoad();
    // A to B, clocked
    dirAtoB = 1; aEnable = 1; parMode = 1; asyncMode = 0; aIn = 8'hA5;
    #2;
    check("R3 no change before edge", bOut, 8'h00);
    tick();
    check("R3 A to B after edge", bOut, 8'hA5);
    check("R1 bOe", {7'b0, bOe}, 8'h01);
    check("R1 aOe", {7'b0, aOe}, 8'h00);
    // B to A, clocked
    dirAtoB = 0; bIn = 8'h3C;
    tick();
    check("R3 B to A after edge", aOut, 8'h3C);
    check("R2 aOe", {7'b0, aOe}, 8'h01);
    check("R2 bOe", {7'b0, bOe}, 8'h00);
    aEnable = 0;
    #1;
    check("R2 A floated", {7'b0, aOe}, 8'h00);
  endtask

  task automatic testHold();
    dirAtoB = 1; aEnable = 0; parMode = 1; asyncMode = 0; aIn = 8'hFF;
    for (int i = 0; i < 3; i++) begin
      tick();
      aIn = ~aIn;
      check("R5 recirculation hold", bOut, 8'h3C);
    end
  endtask

  task automatic testTransparent();
    dirAtoB = 1; aEnable = 1; parMode = 1; asyncMode = 1; aIn = 8'h5A;
    #1;
    check("R4 follows A at once", bOut, 8'h5A);
    aIn = 8'h81;
    #1;
    check("R4 follows new A", bOut, 8'h81);
    tick();
    aEnable = 0; asyncMode = 0; aIn = 8'h00;
    tick();
    check("R4 keeps last word", bOut, 8'h81);
    dirAtoB = 0; aEnable = 1; asyncMode = 1; bIn = 8'h69;
    #1;
    check("R4 follows B at once", aOut, 8'h69);
    tick();
  endtask

  task automatic testSerialFill();
    logic [7:0] pattern = 8'b1011_0010;
    logic [7:0] model   = 8'h69;
    dirAtoB = 1; aEnable = 1; parMode = 0; asyncMode = 0;
    for (int i = 7; i >= 0; i--) begin
      serIn = pattern[i];
      tick();
      model = {model[6:0], pattern[i]};
      check("R6 shift step", bOut, model);
      check("R8 tail bit", {7'b0, serOut}, {7'b0, model[7]});
    end
    check("R6 full fill", bOut, pattern);
  endtask

  task automatic testAsyncSerial();
    logic [7:0] model = 8'b1011_0010;
    parMode = 0; asyncMode = 1; serIn = 1'b1;
    #2;
    serIn = 1'b0;
    #2;
    check("R7 no move between edges", bOut, model);
    serIn = 1'b1;
    tick();
    model = {model[6:0], 1'b1};
    check("R7 moves on edge", bOut, model);
    check("R8 tail after edge", {7'b0, serOut}, {7'b0, model[7]});
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    #5;
    doReset();
    testSyncLoad();
    testHold();
    testTransparent();
    testSerialFill();
    testAsyncSerial();
    parMode = 1; asyncMode = 0;
    doReset();
    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule